// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block arbitrates between eight already-captured interrupt request lines. Each cycle it removes masked lines from the request vector and searches what is left for the highest-priority line. The search starts at a rotating base line and wraps around. The block raises its interrupt output only when that winner outranks everything currently in service. It owns the in-service vector, the rotating base and a rotate-on-auto-EOI flag. It updates them from an acknowledge strobe and from a 3-bit command code that comes with a 3-bit level operand.

The surrounding controller handles edge or level capture of the requests, register decode and vector formation. It presents the request vector, the mask vector and the mode inputs (auto-EOI, special mask, special fully nested, cascade master). It issues an acknowledge when the processor takes the interrupt. The resolved line, the in-service vector and the current base are all visible on the ports.

Top module: `irq_rank_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `isr_out` is 0, `prio_base` is 0, the rotate-on-auto-EOI flag is clear and `int_req` is 0. Reset is asynchronous and active low.
- R2: Priority rank 0 belongs to line `prio_base`, and ranks rise by one per line, wrapping from 7 back to 0. `int_line` names the unmasked requesting line with the lowest rank.
- R3: A line whose `mask_vec` bit is 1 never wins. With no unmasked request, `int_req` is 0.
- R4: `int_req` is 1 one cycle after the inputs and state show a winner whose rank is strictly lower than the lowest rank in the in-service set. An equal or higher rank gives 0.
- R5: With `smm_en` = 1, masked lines are removed from the in-service set before its rank is computed.
- R6: With `sfn_en` = 1 and `is_master` = 1, in-service bit 2 (the cascade line) is ignored in the in-service rank. With `is_master` = 0 it counts.
- R7: `ack` = 1 with `aeoi_en` = 0 and a winner present sets that line's `isr_out` bit at the next edge. `ack` with no winner changes nothing.
- R8: `ack` with `aeoi_en` = 1 leaves `isr_out` unchanged. If the rotate flag is set (command 6 sets it, 7 clears it), `prio_base` becomes winner+1 mod 8.
- R9: Command 1 clears the in-service bit with the lowest rank. Command 2 does the same and also sets `prio_base` to that line+1 mod 8. With `isr_out` = 0, both leave all state unchanged.
- R10: Command 3 clears `isr_out[op_level]`. Command 4 does the same and also sets `prio_base` to `op_level`+1 mod 8.
- R11: Command 5 sets `prio_base` to `op_level`+1 mod 8. Command 0 does nothing.
- R12: When `ack` and a command fall in the same cycle, the command's clear is applied before the acknowledge's set. A base change from the command overrides the auto-EOI rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vec | input | 8 | Captured interrupt requests |
| mask_vec | input | 8 | Per-line mask, 1 = masked |
| aeoi_en | input | 1 | Automatic end-of-interrupt mode |
| smm_en | input | 1 | Special mask mode |
| sfn_en | input | 1 | Special fully nested mode |
| is_master | input | 1 | Unit is the cascade master |
| ack | input | 1 | Acknowledge of the current winner |
| op_cmd | input | 3 | Command code (0 none, 1..7 as in R8-R11) |
| op_level | input | 3 | Line or level operand of the command |
| int_req | output | 1 | Registered interrupt request |
| int_line | output | 3 | Registered winning line |
| isr_out | output | 8 | In-service vector |
| prio_base | output | 3 | Current rotation base |

## Verification
An acknowledge and an end-of-interrupt command can land in the same cycle. The bench provokes this by keeping one line in service while a higher line requests. It then pulses `ack` together with a specific EOI that names the old line, and expects `isr_out` to hold only the new line. It also pairs an auto-EOI acknowledge, with rotation enabled, with a set-base command and expects the command's base value to win.

// File: rtl/irq_rank_pkg.sv
package irq_rank_pkg;

  typedef enum logic [2:0] {
    CMD_NOP        = 3'd0,
    CMD_EOI_NS     = 3'd1,
    CMD_EOI_NS_ROT = 3'd2,
    CMD_EOI_SP     = 3'd3,
    CMD_EOI_SP_ROT = 3'd4,
    CMD_SET_BASE   = 3'd5,
    CMD_AROT_ON    = 3'd6,
    CMD_AROT_OFF   = 3'd7
  } rank_cmd_e;

endpackage

// File: rtl/prio_scan.sv
// Rotated priority search: rank 0 sits at line 'base', wrapping.
// NLINES must be a power of two so the line sum wraps by truncation.
module prio_scan #(
  parameter int NLINES = 8,
  parameter int LW     = $clog2(NLINES)
) (
  input  logic [NLINES-1:0] vec,
  input  logic [LW-1:0]     base,
  output logic [LW:0]       rank,
  output logic [LW-1:0]     line,
  output logic              any
);

  localparam int PW = LW + 1;

  logic [2*NLINES-1:0] dbl;
  logic [NLINES-1:0]   rot;

  always_comb begin
    dbl = {vec, vec} >> base;
    rot = dbl[NLINES-1:0];
    rank = PW'(NLINES);
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (rot[i]) rank = PW'(i);
    end
  end

  assign any  = |vec;
  assign line = rank[LW-1:0] + base;

endmodule

// File: rtl/isr_ctrl.sv
// In-service vector, rotation base and rotate-on-auto-EOI flag.
module isr_ctrl
  import irq_rank_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int LW     = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack,
  input  logic              hit,
  input  logic [LW-1:0]     win_line,
  input  rank_cmd_e         cmd,
  input  logic [LW-1:0]     level,
  input  logic              auto_eoi,
  input  logic [LW-1:0]     top_line,
  input  logic              top_any,
  output logic [NLINES-1:0] isr_q,
  output logic [LW-1:0]     base_q,
  output logic              arot_q
);

  logic [NLINES-1:0] isr_d, clr_v, set_v;
  logic [LW-1:0]     base_d;
  logic              arot_d;
  logic              cmd_moves;
  logic              st_en;

  always_comb begin
    clr_v     = '0;
    set_v     = '0;
    base_d    = base_q;
    arot_d    = arot_q;
    cmd_moves = 1'b0;
    case (cmd)
      CMD_EOI_NS: begin
        if (top_any) clr_v[top_line] = 1'b1;
      end
      CMD_EOI_NS_ROT: begin
        if (top_any) begin
          clr_v[top_line] = 1'b1;
          base_d          = top_line + LW'(1);
          cmd_moves       = 1'b1;
        end
      end
      CMD_EOI_SP: clr_v[level] = 1'b1;
      CMD_EOI_SP_ROT: begin
        clr_v[level] = 1'b1;
        base_d       = level + LW'(1);
        cmd_moves    = 1'b1;
      end
      CMD_SET_BASE: begin
        base_d    = level + LW'(1);
        cmd_moves = 1'b1;
      end
      CMD_AROT_ON:  arot_d = 1'b1;
      CMD_AROT_OFF: arot_d = 1'b0;
      default: ;
    endcase
    if (ack && hit) begin
      if (!auto_eoi) begin
        set_v[win_line] = 1'b1;
      end else if (arot_q && !cmd_moves) begin
        base_d = win_line + LW'(1);
      end
    end
    isr_d = (isr_q & ~clr_v) | set_v;
  end

  assign st_en = ack || (cmd != CMD_NOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      base_q <= '0;
      arot_q <= 1'b0;
    end else if (st_en) begin
      isr_q  <= isr_d;
      base_q <= base_d;
      arot_q <= arot_d;
    end
  end

  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && hit && !auto_eoi) |=> isr_q[$past(win_line)]); // R7

  AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && auto_eoi && cmd == CMD_NOP) |=> isr_q == $past(isr_q)); // R8

  AST_AEOI_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && hit && auto_eoi && arot_q && cmd == CMD_NOP)
      |=> base_q == $past(win_line) + LW'(1)); // R8

  AST_NS_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_EOI_NS && isr_q == '0 && !ack)
      |=> (isr_q == '0) && $stable(base_q)); // R9

  AST_SP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_EOI_SP && !(ack && hit && !auto_eoi))
      |=> !isr_q[$past(level)]); // R10

  AST_SET_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_SET_BASE) |=> base_q == $past(level) + LW'(1)); // R11

endmodule

// File: rtl/irq_rank_unit.sv
module irq_rank_unit
  import irq_rank_pkg::*;
#(
  parameter int NLINES   = 8,
  parameter int CASC_BIT = 2,
  parameter int LW       = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] req_vec,
  input  logic [NLINES-1:0] mask_vec,
  input  logic              aeoi_en,
  input  logic              smm_en,
  input  logic              sfn_en,
  input  logic              is_master,
  input  logic              ack,
  input  logic [2:0]        op_cmd,
  input  logic [LW-1:0]     op_level,
  output logic              int_req,
  output logic [LW-1:0]     int_line,
  output logic [NLINES-1:0] isr_out,
  output logic [LW-1:0]     prio_base
);

  logic [NLINES-1:0] cand_vec, svc_vec, isr_q;
  logic [LW-1:0]     base_q;
  logic              arot_q;
  logic [LW:0]       cand_rank, svc_rank, top_rank;
  logic [LW-1:0]     cand_line, svc_line, top_line;
  logic              cand_any, svc_any, top_any;
  logic              hit;
  logic              req_q;
  logic [LW-1:0]     line_q;
  rank_cmd_e         cmd;

  assign cmd      = rank_cmd_e'(op_cmd);
  assign cand_vec = req_vec & ~mask_vec;

  always_comb begin
    svc_vec = isr_q;
    if (smm_en) svc_vec = svc_vec & ~mask_vec;
    if (sfn_en && is_master) svc_vec[CASC_BIT] = 1'b0;
  end

  prio_scan #(.NLINES(NLINES), .LW(LW)) u_cand (
    .vec(cand_vec), .base(base_q), .rank(cand_rank), .line(cand_line), .any(cand_any));

  prio_scan #(.NLINES(NLINES), .LW(LW)) u_svc (
    .vec(svc_vec), .base(base_q), .rank(svc_rank), .line(svc_line), .any(svc_any));

  prio_scan #(.NLINES(NLINES), .LW(LW)) u_top (
    .vec(isr_q), .base(base_q), .rank(top_rank), .line(top_line), .any(top_any));

  assign hit = cand_any && (cand_rank < svc_rank);

  isr_ctrl #(.NLINES(NLINES), .LW(LW)) u_state (
    .clk(clk), .rst_n(rst_n), .ack(ack), .hit(hit), .win_line(cand_line),
    .cmd(cmd), .level(op_level), .auto_eoi(aeoi_en),
    .top_line(top_line), .top_any(top_any),
    .isr_q(isr_q), .base_q(base_q), .arot_q(arot_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      line_q <= '0;
    end else begin
      req_q  <= hit;
      line_q <= cand_line;
    end
  end

  assign int_req   = req_q;
  assign int_line  = line_q;
  assign isr_out   = isr_q;
  assign prio_base = base_q;

  AST_NO_CAND_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_vec == '0) |=> !int_req); // R3

  AST_REQ_LINE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !smm_en && !(sfn_en && is_master))
      |=> !isr_out[int_line] || $past(ack)); // R4

endmodule

// File: tb/sim_irq_rank_unit.sv
module sim_irq_rank_unit;
  import irq_rank_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req_vec, mask_vec;
  logic       aeoi_en, smm_en, sfn_en, is_master, ack;
  logic [2:0] op_cmd, op_level;
  logic       int_req;
  logic [2:0] int_line;
  logic [7:0] isr_out;
  logic [2:0] prio_base;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_rank_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .mask_vec(mask_vec),
    .aeoi_en(aeoi_en), .smm_en(smm_en), .sfn_en(sfn_en), .is_master(is_master),
    .ack(ack), .op_cmd(op_cmd), .op_level(op_level),
    .int_req(int_req), .int_line(int_line), .isr_out(isr_out), .prio_base(prio_base));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    tick();
    tick();
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_cmd(rank_cmd_e c, logic [2:0] l);
    op_cmd = c;
    op_level = l;
    tick();
    op_cmd = CMD_NOP;
    op_level = 3'd0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "isr", isr_out, 0);
    chk("R1", "base", prio_base, 0);
    chk("R1", "int_req", int_req, 0);
  endtask

  task automatic t_rotation();
    req_vec = 8'h81;
    settle();
    chk("R2", "int_req base0", int_req, 1);
    chk("R2", "line base0", int_line, 0);
    do_cmd(CMD_SET_BASE, 3'd6);
    chk("R11", "base after set", prio_base, 7);
    settle();
    chk("R2", "line base7", int_line, 7);
    mask_vec = 8'h80;
    settle();
    chk("R3", "line masked7", int_line, 0);
    mask_vec = 8'hFF;
    settle();
    chk("R3", "all masked", int_req, 0);
    mask_vec = 8'h00;
    req_vec = 8'h00;
    do_cmd(CMD_SET_BASE, 3'd7);
    chk("R11", "base wrap", prio_base, 0);
  endtask

  task automatic t_nesting();
    req_vec = 8'h08;
    settle();
    do_ack();
    chk("R7", "ack sets isr", isr_out, 8'h08);
    settle();
    chk("R4", "equal rank blocked", int_req, 0);
    req_vec = 8'h0A;
    settle();
    chk("R4", "higher rank req", int_req, 1);
    chk("R4", "higher rank line", int_line, 1);
    req_vec = 8'h28;
    settle();
    chk("R4", "lower rank blocked", int_req, 0);
    do_cmd(CMD_EOI_NS, 3'd0);
    chk("R9", "ns eoi clears", isr_out, 0);
    req_vec = 8'h00;
    settle();
    do_cmd(CMD_EOI_NS, 3'd0);
    chk("R9", "ns eoi empty isr", isr_out, 0);
    chk("R9", "ns eoi empty base", prio_base, 0);
    do_ack();
    chk("R7", "ack without winner", isr_out, 0);
  endtask

  task automatic t_rot_eoi();
    req_vec = 8'h20;
    tick();
    do_ack();
    req_vec = 8'h04;
    tick();
    do_ack();
    chk("R7", "two in service", isr_out, 8'h24);
    req_vec = 8'h00;
    do_cmd(CMD_EOI_NS_ROT, 3'd0);
    chk("R9", "rot eoi isr", isr_out, 8'h20);
    chk("R9", "rot eoi base", prio_base, 3);
    do_cmd(CMD_EOI_SP, 3'd5);
    chk("R10", "sp eoi isr", isr_out, 0);
    do_cmd(CMD_EOI_SP_ROT, 3'd4);
    chk("R10", "sp rot base", prio_base, 5);
    do_cmd(CMD_SET_BASE, 3'd7);
  endtask

  task automatic t_special_mask();
    req_vec = 8'h10;
    tick();
    do_ack();
    req_vec = 8'h40;
    settle();
    chk("R5", "blocked without smm", int_req, 0);
    smm_en = 1'b1;
    mask_vec = 8'h10;
    settle();
    chk("R5", "smm int_req", int_req, 1);
    chk("R5", "smm line", int_line, 6);
    smm_en = 1'b0;
    mask_vec = 8'h00;
    req_vec = 8'h00;
    do_cmd(CMD_EOI_SP, 3'd4);
  endtask

  task automatic t_cascade();
    req_vec = 8'h04;
    tick();
    do_ack();
    sfn_en = 1'b1;
    is_master = 1'b1;
    settle();
    chk("R6", "master ignores bit2", int_req, 1);
    chk("R6", "master line", int_line, 2);
    is_master = 1'b0;
    settle();
    chk("R6", "non-master counts bit2", int_req, 0);
    sfn_en = 1'b0;
    req_vec = 8'h00;
    do_cmd(CMD_EOI_SP, 3'd2);
    chk("R10", "sp eoi bit2", isr_out, 0);
  endtask

  task automatic t_auto_eoi();
    aeoi_en = 1'b1;
    req_vec = 8'h08;
    tick();
    do_ack();
    chk("R8", "aeoi isr", isr_out, 0);
    chk("R8", "aeoi no rotate", prio_base, 0);
    do_cmd(CMD_AROT_ON, 3'd0);
    do_ack();
    chk("R8", "aeoi rotate base", prio_base, 4);
    chk("R8", "aeoi rotate isr", isr_out, 0);
    do_cmd(CMD_AROT_OFF, 3'd0);
    do_cmd(CMD_SET_BASE, 3'd7);
    aeoi_en = 1'b0;
    req_vec = 8'h00;
  endtask

  task automatic t_same_cycle();
    req_vec = 8'h40;
    tick();
    do_ack();
    req_vec = 8'h02;
    tick();
    ack = 1'b1;
    op_cmd = CMD_EOI_SP;
    op_level = 3'd6;
    tick();
    ack = 1'b0;
    op_cmd = CMD_NOP;
    op_level = 3'd0;
    chk("R12", "ack plus sp eoi", isr_out, 8'h02);
    req_vec = 8'h00;
    do_cmd(CMD_EOI_SP, 3'd1);
    aeoi_en = 1'b1;
    do_cmd(CMD_AROT_ON, 3'd0);
    req_vec = 8'h02;
    tick();
    ack = 1'b1;
    op_cmd = CMD_SET_BASE;
    op_level = 3'd4;
    tick();
    ack = 1'b0;
    op_cmd = CMD_NOP;
    op_level = 3'd0;
    chk("R12", "command base wins", prio_base, 5);
    chk("R12", "aeoi isr untouched", isr_out, 0);
    aeoi_en = 1'b0;
    req_vec = 8'h00;
  endtask

  initial begin
    rst_n = 1'b0;
    req_vec = '0; mask_vec = '0;
    aeoi_en = 0; smm_en = 0; sfn_en = 0; is_master = 0; ack = 0;
    op_cmd = CMD_NOP; op_level = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    settle();
    t_reset();
    t_rotation();
    t_nesting();
    t_rot_eoi();
    t_special_mask();
    t_cascade();
    t_auto_eoi();
    t_same_cycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule